// File: doc/BRIEF.md
# Packed Nucleotide Stream Unpacker

The unpacker sits between a word-wide input FIFO and a base-serial alignment array. Each 32-bit FIFO word holds eight 4-bit fields. Within a field, the two low bits carry a nucleotide code and bit 2 marks the first base of a new sequence. Bit 3 carries no meaning and is dropped. The block pops a word, presents its fields one per clock on a valid/ready output, lowest nibble first, and pops the following word in the same cycle that the last field is taken. A FIFO that is never empty therefore sustains one base per clock with no bubbles.

Sequence boundaries travel in-band. There is no length count. A start marker is passed to the output unchanged wherever it appears, including in the middle of a sequence that is still running, and the consumer closes the old sequence when it sees it. The input FIFO is show-ahead: `fifo_rdata` shows the head word whenever `fifo_empty` is low, and a cycle with `fifo_rd_en` high removes that word. Reset is synchronous and active high, and it throws away any word that has only been partly sent.

The control is a two-state machine:

- **ST_IDLE**: no word is held.
  - LOAD: the FIFO is not empty, so pop a word, set field index 0 and go to ST_EMIT.
- **ST_EMIT**: a word is held and `base_valid` is high.
  - HOLD: ready is low, so keep the index.
  - STEP: a field other than the last is taken, so increment the index.
  - CHAIN: the last field is taken and the FIFO is not empty, so pop the next word, set the index to 0 and stay in ST_EMIT.
  - DRAIN: the last field is taken and the FIFO is empty, so go to ST_IDLE.
- **Reset**: from any state, go to ST_IDLE.

Top module: `nuc_unpacker`

## Requirements
- R1: While `rst` is high, `base_valid` and `fifo_rd_en` are low. After reset the fields left in a partly sent word never appear.
- R2: `base_code` equals bits [1:0] of the current field, with A=00, C=01, G=10, T=11.
- R3: `base_first` equals bit 2 of the current field on every beat, including a marker that arrives while an earlier sequence is still in progress.
- R4: Bit 3 of each field has no effect on any output.
- R5: Each popped word yields exactly eight beats, taken from nibble [3:0] up to nibble [31:28].
- R6: `fifo_rd_en` is never high while `fifo_empty` is high.
- R7: In ST_IDLE a non-empty FIFO is popped at once, and `base_valid` is high in the next cycle.
- R8: When the eighth beat of a word is accepted and the FIFO is not empty, the next word is popped in that same cycle, so the beats continue with no idle cycle.
- R9: While `base_valid` is high and `base_ready` is low, `base_valid`, `base_code` and `base_first` hold their values into the next cycle.
- R10: When no word is held and the FIFO is empty, `base_valid` is low, and it goes low in the cycle after the eighth beat is accepted from an empty FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | Input FIFO holds no word |
| fifo_rdata | input | 32 | Head word of the show-ahead FIFO |
| fifo_rd_en | output | 1 | Pop the head word this cycle |
| base_valid | output | 1 | A base is presented |
| base_ready | input | 1 | Consumer takes the base this cycle |
| base_code | output | 2 | Nucleotide code of the presented base |
| base_first | output | 1 | Presented base starts a sequence |

## Verification
The hardest case to reach is the word handover under stall. The eighth field of a word must be accepted in exactly the cycle when the FIFO has just been refilled, or has just been drained, and it must be preceded by several cycles with ready low. A long run therefore toggles ready at random and pushes words at random moments while the FIFO stays shallow. This lands the last-field acceptance on both the CHAIN and the DRAIN branch many times, both straight after a stall and without one. A reset issued a few beats into a word, while the FIFO still holds data, confirms that the remaining fields are dropped.

// File: rtl/nuc_unpack_pkg.sv
package nuc_unpack_pkg;
    typedef enum logic {
        ST_IDLE,
        ST_EMIT
    } unpack_state_e;
endpackage

// File: rtl/nuc_field_sel.sv
module nuc_field_sel #(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 4,
    localparam int FIELDS = WORD_W / FIELD_W,
    localparam int IDX_W  = $clog2(FIELDS)
) (
    input  logic [WORD_W-1:0]  word_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [FIELD_W-1:0] field_o
);
    logic [FIELD_W-1:0] fld [FIELDS];

    for (genvar g = 0; g < FIELDS; g++) begin : g_fld
        assign fld[g] = word_i[g*FIELD_W +: FIELD_W];
    end

    assign field_o = fld[idx_i];
endmodule

// File: rtl/nuc_unpack_ctrl.sv
module nuc_unpack_ctrl
    import nuc_unpack_pkg::*;
#(
    parameter int FIELDS = 8,
    localparam int IDX_W = $clog2(FIELDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_empty,
    input  logic             out_ready,
    output logic             load,
    output logic             out_valid,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(FIELDS - 1);

    unpack_state_e    state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    // next state and index
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!fifo_empty) begin          // LOAD
                    idx_d   = '0;
                    state_d = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (idx_q != LAST) begin    // STEP
                        idx_d = idx_q + IDX_W'(1);
                    end else if (!fifo_empty) begin  // CHAIN
                        idx_d = '0;
                    end else begin              // DRAIN
                        state_d = ST_IDLE;
                    end
                end                             // HOLD otherwise
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // outputs
    always_comb begin
        load      = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: load = !fifo_empty;
            ST_EMIT: begin
                out_valid = 1'b1;
                load      = out_ready && (idx_q == LAST) && !fifo_empty;
            end
            default: ;
        endcase
        if (rst) begin
            load      = 1'b0;
            out_valid = 1'b0;
        end
    end

    assign idx = idx_q;
endmodule

// File: rtl/nuc_unpacker.sv
module nuc_unpacker #(
    parameter int WORD_W  = 32,
    parameter int FIELD_W = 4,
    parameter int CODE_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_rdata,
    output logic              fifo_rd_en,
    output logic              base_valid,
    input  logic              base_ready,
    output logic [CODE_W-1:0] base_code,
    output logic              base_first
);
    localparam int FIELDS   = WORD_W / FIELD_W;
    localparam int IDX_W    = $clog2(FIELDS);
    localparam int MARK_BIT = CODE_W;

    logic [WORD_W-1:0]  word_q;
    logic [IDX_W-1:0]   idx;
    logic [FIELD_W-1:0] field;
    logic               load;
    logic [FIELD_W-1:MARK_BIT+1] pad_unused;

    nuc_unpack_ctrl #(.FIELDS(FIELDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .out_ready  (base_ready),
        .load       (load),
        .out_valid  (base_valid),
        .idx        (idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= fifo_rdata;
        end
    end

    nuc_field_sel #(.WORD_W(WORD_W), .FIELD_W(FIELD_W)) u_sel (
        .word_i  (word_q),
        .idx_i   (idx),
        .field_o (field)
    );

    assign fifo_rd_en = load;
    assign base_code  = field[CODE_W-1:0];
    assign base_first = field[MARK_BIT];
    assign pad_unused = field[FIELD_W-1:MARK_BIT+1];
endmodule

// File: rtl/nuc_unpacker_chk.sv
module nuc_unpacker_chk #(
    parameter int FIELDS = 8,
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_empty,
    input logic              fifo_rd_en,
    input logic              base_valid,
    input logic              base_ready,
    input logic [CODE_W-1:0] base_code,
    input logic              base_first
);
    localparam int CNT_W = $clog2(FIELDS) + 1;

    logic [CNT_W-1:0] beats_q;

    always_ff @(posedge clk) begin
        if (rst || fifo_rd_en) begin
            beats_q <= '0;
        end else if (base_valid && base_ready) begin
            beats_q <= beats_q + CNT_W'(1);
        end
    end

    // R1
    always @(posedge clk) begin
        if (rst) begin
            rst_quiet_chk: assert (!base_valid && !fifo_rd_en);
        end
    end

    // R6
    no_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |-> !fifo_empty);

    // R7
    pop_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_en |=> base_valid);

    // R8
    chain_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (base_valid && base_ready && beats_q == CNT_W'(FIELDS - 1) && !fifo_empty)
        |-> fifo_rd_en);

    // R5
    eight_beats_chk: assert property (@(posedge clk) disable iff (rst)
        (base_valid && base_ready && beats_q == CNT_W'(FIELDS - 1) && fifo_empty)
        |=> !base_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (base_valid && !base_ready)
        |=> (base_valid && $stable(base_code) && $stable(base_first)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!base_valid && fifo_empty) |=> !base_valid);
endmodule

bind nuc_unpacker nuc_unpacker_chk #(.FIELDS(FIELDS), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_rd_en (fifo_rd_en),
    .base_valid (base_valid),
    .base_ready (base_ready),
    .base_code  (base_code),
    .base_first (base_first)
);

// File: tb/nuc_unpacker_tb.sv
`timescale 1ns/1ps
module nuc_unpacker_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_empty = 1'b1;
    logic [31:0] fifo_rdata = '0;
    logic        fifo_rd_en;
    logic        base_valid;
    logic        base_ready = 1'b0;
    logic [1:0]  base_code;
    logic        base_first;

    always #2.5 clk = ~clk;

    nuc_unpacker u_dut (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_rdata (fifo_rdata),
        .fifo_rd_en (fifo_rd_en),
        .base_valid (base_valid),
        .base_ready (base_ready),
        .base_code  (base_code),
        .base_first (base_first)
    );

    logic [31:0] fq[$];   // bench FIFO contents
    logic [3:0]  eq[$];   // fields still owed by the model
    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    bit done = 1'b0;

    bit          s_rst = 1'b1, s_fire = 1'b0, s_load = 1'b0, s_pop = 1'b0;
    logic [31:0] s_word = '0;

    function automatic logic [31:0] rand_word();
        logic [31:0] w;
        for (int i = 0; i < 8; i++) begin
            w[i*4 +: 2] = 2'($urandom_range(0, 3));
            w[i*4 + 2]  = ($urandom_range(0, 11) == 0);
            w[i*4 + 3]  = 1'($urandom_range(0, 1));
        end
        return w;
    endfunction

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    task automatic step(input bit r, input bit rdy, input int npush);
        bit ev, erd;
        @(negedge clk);
        cyc++;
        // effects of the previous edge
        if (s_pop && fq.size() > 0) void'(fq.pop_front());
        if (s_rst) begin
            eq.delete();
        end else begin
            if (s_fire) void'(eq.pop_front());
            if (s_load) for (int i = 0; i < 8; i++) eq.push_back(s_word[i*4 +: 4]);
        end
        for (int i = 0; i < npush; i++) fq.push_back(rand_word());
        rst        = r;
        base_ready = rdy;
        fifo_empty = (fq.size() == 0);
        fifo_rdata = (fq.size() == 0) ? 32'h0 : fq[0];
        #1;
        ev  = !r && (eq.size() > 0);
        erd = !r && !fifo_empty && (eq.size() == 0 || (eq.size() == 1 && rdy));
        vectors++;
        if (base_valid !== ev) begin
            miscompares++;
            $display("FAIL R1/R7/R10 cycle %0d valid got %b exp %b", cyc, base_valid, ev);
        end
        if (fifo_rd_en !== erd) begin
            miscompares++;
            $display("FAIL R6/R8 cycle %0d rd_en got %b exp %b", cyc, fifo_rd_en, erd);
        end
        if (ev) begin
            if (base_code !== eq[0][1:0]) begin
                miscompares++;
                $display("FAIL R2/R5/R9 cycle %0d code got %b exp %b", cyc, base_code, eq[0][1:0]);
            end
            if (base_first !== eq[0][2]) begin
                miscompares++;
                $display("FAIL R3/R4 cycle %0d first got %b exp %b", cyc, base_first, eq[0][2]);
            end
        end
        s_rst  = r;
        s_fire = ev && rdy;
        s_load = erd;
        s_pop  = fifo_rd_en;
        s_word = fifo_rdata;
    endtask

    task automatic push_fixed(input logic [31:0] w);
        fq.push_back(w);
    endtask

    initial begin
        // R1: reset state with empty FIFO
        repeat (3) step(1'b1, 1'b1, 0);
        // R10: idle with nothing queued
        repeat (3) step(1'b0, 1'b1, 0);
        // R5, R8: back-to-back words at full rate
        step(1'b0, 1'b1, 4);
        repeat (40) step(1'b0, 1'b1, 0);
        // R2, R3, R4: all codes, markers mid-sequence, bit 3 flipped
        push_fixed(32'h7654_3210);
        push_fixed(32'hFEDC_BA98);
        push_fixed(32'h4044_0404);
        repeat (30) step(1'b0, 1'b1, 0);
        // R7, R9: word arrives while the consumer stalls
        step(1'b0, 1'b0, 1);
        repeat (5) step(1'b0, 1'b0, 0);
        repeat (12) step(1'b0, 1'b1, 0);
        // R9, R6, R8, R10: random ready and sparse pushes
        for (int k = 0; k < 3000; k++) begin
            int n;
            n = (fq.size() < 3 && $urandom_range(0, 5) == 0) ? 1 : 0;
            step(1'b0, ($urandom_range(0, 3) != 0), n);
        end
        // R1: reset in the middle of a word with data still queued
        step(1'b0, 1'b1, 2);
        repeat (3) step(1'b0, 1'b1, 0);
        step(1'b1, 1'b1, 0);
        repeat (25) step(1'b0, 1'b1, 0);
        // R10: full drain
        repeat (20) step(1'b0, 1'b1, 0);
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired, got running exp finished");
            report();
            $finish;
        end
    end
endmodule